// File: doc/BRIEF.md
# Packed Half-Precision Reciprocal Square Root

This block is a SIMD datapath that returns, for every 16-bit lane of a vector of half-precision values, an approximation of one over the square root of that lane. The lane count is a parameter. The intended sizes are 8, 16 or 32 lanes. Positive finite operands take a fixed-latency path. That path normalizes the operand, including subnormals, and splits off the exponent parity. A 7-bit index, made of the parity bit and the six leading fraction bits, addresses a table of root samples. The block interpolates linearly between neighbouring samples and rounds the result to half precision. Zeros, infinities, negatives and NaNs take fixed results instead.

Each lane also has a write mask bit. A lane with its bit set takes the new result. A lane with its bit clear either keeps the lane from the old destination vector or is forced to zero, depending on the zeroing flag. A broadcast flag feeds source element 0 to every lane. The unit has a two-stage pipeline, accepts one vector per cycle and signals no floating-point exceptions.

Top module: `fp16_rsqrt_vec`

## Requirements
- R1: For a positive normal operand that is not an exact power of four, the lane result is a positive normal value whose relative error against the true 1/sqrt(x) is below 2^-11 + 2^-14.
- R2: A positive subnormal operand (exponent field 0, fraction non-zero) is treated as its real value. The lane result is a positive normal value (exponent field bits [14:10] neither 0 nor 31) and meets the R1 error bound.
- R3: An operand that is exactly 2^(-2n) returns exactly 2^n: fraction 0 and exponent field 15+n.
- R4: Any other negative operand returns 16'hFE00. This covers negative normals, negative subnormals and negative infinity (16'hFC00).
- R5: 16'h8000 returns 16'hFC00, 16'h0000 returns 16'h7C00, and 16'h7C00 returns 16'h0000.
- R6: A NaN operand (exponent field 31, fraction non-zero) returns the operand with bit 9 set. Sign and payload are kept.
- R7: Lane i takes its computed result when mask_i[i] is 1. When mask_i[i] is 0, the lane is 16'h0000 if zero_mode_i is 1, and otherwise it is the old destination lane dst_old_i[16*i +: 16].
- R8: With bcast_i at 1, every lane computes from src_i[15:0] and ignores its own source element.
- R9: valid_o follows valid_i by exactly two clock cycles. A new vector is accepted every cycle. After reset, valid_o and res_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input vector strobe |
| src_i | input | 16*LANES | Source vector; lane i in bits [16*i +: 16] |
| dst_old_i | input | 16*LANES | Old destination vector used for merge masking |
| mask_i | input | LANES | Per-lane write mask |
| zero_mode_i | input | 1 | 1: masked-off lanes become zero; 0: they keep the old destination |
| bcast_i | input | 1 | 1: every lane uses source element 0 |
| valid_o | output | 1 | Result strobe, two cycles after valid_i |
| res_o | output | 16*LANES | Result vector |

## Verification
The bound checker runs on every cycle. It checks the two-cycle valid latency, zeroing and merging of masked-off lanes, the fixed results for negative operands, zeros and NaNs, and that subnormal operands give normal results. It evaluates each of these against the broadcast-selected operand. The approximation error bound and the exact powers of four are numeric properties, so only the bench scenarios show them. The bench sweeps every positive finite encoding through the vector and compares each result with a real-valued reference. It adds directed and random vectors that mix masks, zeroing, broadcast and bubbles in the valid stream.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

  localparam int HW      = 16;
  localparam int IDX_W   = 6;
  localparam int FRAC_W  = 10 - IDX_W;
  localparam int TAB_W   = 17;
  localparam int ENT     = (1 << IDX_W) + 1;

  typedef enum logic [2:0] {
    K_FIN   = 3'd0,
    K_NAN   = 3'd1,
    K_NZERO = 3'd2,
    K_PZERO = 3'd3,
    K_NEG   = 3'd4,
    K_PINF  = 3'd5
  } kind_e;

  typedef struct packed {
    kind_e              kind;
    logic [HW-1:0]      raw;
    logic [4:0]         base_exp;
    logic [TAB_W-1:0]   t0;
    logic [TAB_W-1:0]   t1;
    logic [FRAC_W-1:0]  frac;
  } s1_t;

  function automatic logic [31:0] isqrt64(input logic [63:0] v);
    logic [63:0] x, r, b;
    x = v;
    r = '0;
    b = 64'h4000_0000_0000_0000;
    for (int k = 0; k < 32; k++) begin
      if (x >= r + b) begin
        x = x - (r + b);
        r = (r >> 1) + b;
      end else begin
        r = r >> 1;
      end
      b = b >> 2;
    end
    return r[31:0];
  endfunction

  // 2^16 / sqrt(y), y = (1 + j/64) * (1 + p), rounded to nearest
  function automatic logic [TAB_W-1:0] lut_val(input int p, input int j);
    logic [63:0] den, n;
    logic [31:0] r;
    den = 64'(((1 << IDX_W) + j) * (p + 1));
    n   = (64'd1 << (32 + 2 + IDX_W)) / den;
    r   = isqrt64(n);
    return TAB_W'((r + 32'd1) >> 1);
  endfunction

endpackage

// File: rtl/rsqrt_lut.sv
module rsqrt_lut
  import rsqrt_pkg::*;
(
  input  logic             par_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [TAB_W-1:0] t0_o,
  output logic [TAB_W-1:0] t1_o
);

  logic [TAB_W-1:0] tab [2*ENT];

  for (genvar p = 0; p < 2; p++) begin : g_par
    for (genvar j = 0; j < ENT; j++) begin : g_ent
      localparam logic [TAB_W-1:0] TV = lut_val(p, j);
      assign tab[p*ENT + j] = TV;
    end
  end

  logic [7:0] base;
  assign base = par_i ? 8'(ENT) : 8'd0;
  assign t0_o = tab[base + 8'(idx_i)];
  assign t1_o = tab[base + 8'(idx_i) + 8'd1];

endmodule

// File: rtl/rsqrt_lane_front.sv
module rsqrt_lane_front
  import rsqrt_pkg::*;
(
  input  logic [HW-1:0] op_i,
  output s1_t           s1_o
);

  logic [4:0]        ex;
  logic [9:0]        mn;
  logic [3:0]        msb;
  logic [3:0]        sh;
  logic [9:0]        nfr;
  logic signed [5:0] e6, ee6, half;
  logic              par;
  kind_e             kind;

  assign ex = op_i[14:10];
  assign mn = op_i[9:0];

  always_comb begin
    msb = '0;
    for (int b = 0; b < 10; b++) if (mn[b]) msb = 4'(b);
    sh = 4'(4'd10 - msb);
    if (ex != 5'd0) begin
      nfr = mn;
      e6  = $signed({1'b0, ex}) - 6'sd15;
    end else begin
      nfr = 10'(mn << sh);  // leading one drops out
      e6  = -6'sd14 - $signed({2'b0, sh});
    end
    par  = e6[0];
    ee6  = e6 - $signed({5'b0, par});
    half = ee6 >>> 1;
  end

  always_comb begin
    if (ex == 5'd31 && mn != 10'd0)      kind = K_NAN;
    else if (ex == 5'd0 && mn == 10'd0)  kind = op_i[15] ? K_NZERO : K_PZERO;
    else if (op_i[15])                   kind = K_NEG;
    else if (ex == 5'd31)                kind = K_PINF;
    else                                 kind = K_FIN;
  end

  logic [TAB_W-1:0] t0, t1;

  rsqrt_lut u_lut (
    .par_i (par),
    .idx_i (nfr[9 -: IDX_W]),
    .t0_o  (t0),
    .t1_o  (t1)
  );

  always_comb begin
    s1_o.kind     = kind;
    s1_o.raw      = op_i;
    s1_o.base_exp = 5'(6'sd14 - half);
    s1_o.t0       = t0;
    s1_o.t1       = t1;
    s1_o.frac     = nfr[FRAC_W-1:0];
  end

endmodule

// File: rtl/rsqrt_lane_back.sv
module rsqrt_lane_back
  import rsqrt_pkg::*;
(
  input  s1_t           s1_i,
  input  logic          wr_i,
  input  logic          zero_i,
  input  logic [HW-1:0] old_i,
  output logic [HW-1:0] lane_o
);

  localparam int RW = TAB_W + FRAC_W;

  logic [TAB_W-1:0] d;
  logic [RW-1:0]    prod, rfull;
  logic [11:0]      rnd;
  logic [HW-1:0]    fin, val;
  logic             unused_bits;

  assign d     = s1_i.t0 - s1_i.t1;
  assign prod  = RW'(d) * RW'(s1_i.frac);
  assign rfull = {s1_i.t0, {FRAC_W{1'b0}}} - prod;
  // r in [0.5,1): leading one at RW-2, keep 10 fraction bits below it
  assign rnd   = {1'b0, rfull[RW-2 -: 11]} + 12'(rfull[RW-13]);
  assign unused_bits = ^{rfull[RW-14:0], rnd[10]};

  always_comb begin
    if (rfull[RW-1] || rnd[11]) fin = {1'b0, s1_i.base_exp + 5'd1, 10'd0};
    else                        fin = {1'b0, s1_i.base_exp, rnd[9:0]};
  end

  always_comb begin
    unique case (s1_i.kind)
      K_NAN:   val = s1_i.raw | 16'h0200;
      K_NZERO: val = 16'hFC00;
      K_PZERO: val = 16'h7C00;
      K_NEG:   val = 16'hFE00;
      K_PINF:  val = 16'h0000;
      default: val = fin;
    endcase
  end

  assign lane_o = wr_i ? val : (zero_i ? '0 : old_i);

endmodule

// File: rtl/fp16_rsqrt_vec.sv
module fp16_rsqrt_vec
  import rsqrt_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [LANES*HW-1:0] src_i,
  input  logic [LANES*HW-1:0] dst_old_i,
  input  logic [LANES-1:0]    mask_i,
  input  logic                zero_mode_i,
  input  logic                bcast_i,
  output logic                valid_o,
  output logic [LANES*HW-1:0] res_o
);

  localparam int VW = LANES * HW;

  s1_t              s1_d [LANES];
  s1_t              s1_q [LANES];
  logic [VW-1:0]    old_q;
  logic [LANES-1:0] mask_q;
  logic             zero_q, v1_q;
  logic [VW-1:0]    res_d;

  for (genvar i = 0; i < LANES; i++) begin : g_front
    logic [HW-1:0] op;
    assign op = bcast_i ? src_i[HW-1:0] : src_i[i*HW +: HW];
    rsqrt_lane_front u_front (
      .op_i (op),
      .s1_o (s1_d[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      old_q  <= '0;
      mask_q <= '0;
      zero_q <= 1'b0;
      for (int l = 0; l < LANES; l++) s1_q[l] <= '0;
    end else begin
      v1_q   <= valid_i;
      old_q  <= dst_old_i;
      mask_q <= mask_i;
      zero_q <= zero_mode_i;
      for (int l = 0; l < LANES; l++) s1_q[l] <= s1_d[l];
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_back
    rsqrt_lane_back u_back (
      .s1_i   (s1_q[i]),
      .wr_i   (mask_q[i]),
      .zero_i (zero_q),
      .old_i  (old_q[i*HW +: HW]),
      .lane_o (res_d[i*HW +: HW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= v1_q;
      res_o   <= res_d;
    end
  end

endmodule

// File: rtl/rsqrt_vec_chk.sv
module rsqrt_vec_chk #(
  parameter int LANES = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [LANES*16-1:0] src_i,
  input logic [LANES*16-1:0] dst_old_i,
  input logic [LANES-1:0]    mask_i,
  input logic                zero_mode_i,
  input logic                bcast_i,
  input logic                valid_o,
  input logic [LANES*16-1:0] res_o
);

  localparam int VW = LANES * 16;

  logic [1:0]       age;
  logic             v1, v2, z1, z2, b1, b2;
  logic [VW-1:0]    s1, s2, o1, o2;
  logic [LANES-1:0] m1, m2;
  logic             warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age <= '0;
      {v1, v2, z1, z2, b1, b2} <= '0;
      {s1, s2, o1, o2} <= '0;
      {m1, m2} <= '0;
    end else begin
      if (age != 2'd2) age <= age + 2'd1;
      v1 <= valid_i;     v2 <= v1;
      z1 <= zero_mode_i; z2 <= z1;
      b1 <= bcast_i;     b2 <= b1;
      s1 <= src_i;       s2 <= s1;
      o1 <= dst_old_i;   o2 <= o1;
      m1 <= mask_i;      m2 <= m1;
    end
  end

  assign warm = (age == 2'd2);

  p_valid_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> valid_o == v2);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [15:0] op, got;
    logic        take, is_nan, is_zero, is_neg, is_sub;
    assign op      = b2 ? s2[15:0] : s2[i*16 +: 16];
    assign got     = res_o[i*16 +: 16];
    assign take    = warm && valid_o && m2[i];
    assign is_nan  = op[14:10] == 5'd31 && op[9:0] != 10'd0;
    assign is_zero = op[14:0] == 15'd0;
    assign is_neg  = op[15] && !is_nan && !is_zero;
    assign is_sub  = !op[15] && op[14:10] == 5'd0 && op[9:0] != 10'd0;

    p_zero_lane_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      warm && valid_o && z2 && !m2[i] |-> got == 16'h0000);

    p_keep_lane_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      warm && valid_o && !z2 && !m2[i] |-> got == o2[i*16 +: 16]);

    p_neg_indef_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take && is_neg |-> got == 16'hFE00);

    p_signed_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take && is_zero |-> got == (op[15] ? 16'hFC00 : 16'h7C00));

    p_nan_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take && is_nan |-> got == (op | 16'h0200));

    p_sub_normal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take && is_sub |-> !got[15] && got[14:10] != 5'd0 && got[14:10] != 5'd31);
  end

endmodule

bind fp16_rsqrt_vec rsqrt_vec_chk #(.LANES(LANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .src_i       (src_i),
  .dst_old_i   (dst_old_i),
  .mask_i      (mask_i),
  .zero_mode_i (zero_mode_i),
  .bcast_i     (bcast_i),
  .valid_o     (valid_o),
  .res_o       (res_o)
);

// File: tb/fp16_rsqrt_vec_tb_top.sv
`timescale 1ns/1ps
module fp16_rsqrt_vec_tb_top;

  localparam int L  = 8;
  localparam int VW = L * 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [VW-1:0] src_i = '0;
  logic [VW-1:0] dst_old_i = '0;
  logic [L-1:0]  mask_i = '0;
  logic          zero_mode_i = 1'b0;
  logic          bcast_i = 1'b0;
  logic          valid_o;
  logic [VW-1:0] res_o;

  always #2.5 clk_i = ~clk_i;

  fp16_rsqrt_vec #(.LANES(L)) dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  logic          h_v  [4];
  logic [VW-1:0] h_src[4];
  logic [VW-1:0] h_dst[4];
  logic [L-1:0]  h_m  [4];
  logic          h_z  [4];
  logic          h_b  [4];

  function automatic real fp16_val(input logic [15:0] h);
    int ex = int'(h[14:10]);
    int mn = int'(h[9:0]);
    if (ex == 0) return real'(mn) * (2.0 ** -24.0);
    return real'(1024 + mn) * (2.0 ** real'(ex - 25));
  endfunction

  task automatic report(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  task automatic check_lane(input int i, input int sl);
    logic [15:0] op, got, ev;
    logic [4:0]  ex;
    logic [9:0]  mn;
    string       tag;
    bit          approx;
    real         x, want, g, bound;
    got    = res_o[i*16 +: 16];
    op     = h_b[sl] ? h_src[sl][15:0] : h_src[sl][i*16 +: 16];
    approx = 0;
    ev     = '0;
    tag    = (h_b[sl] && i != 0) ? "R8" : "";
    ex     = op[14:10];
    mn     = op[9:0];
    if (!h_m[sl][i]) begin
      tag = "R7";
      ev  = h_z[sl] ? 16'h0000 : h_dst[sl][i*16 +: 16];
    end else if (ex == 5'd31 && mn != 10'd0) begin
      if (tag == "") tag = "R6";
      ev = op | 16'h0200;
    end else if (ex == 5'd0 && mn == 10'd0) begin
      if (tag == "") tag = "R5";
      ev = op[15] ? 16'hFC00 : 16'h7C00;
    end else if (op[15]) begin
      if (tag == "") tag = "R4";
      ev = 16'hFE00;
    end else if (ex == 5'd31) begin
      if (tag == "") tag = "R5";
      ev = 16'h0000;
    end else if (ex != 5'd0 && mn == 10'd0 && ex[0]) begin
      if (tag == "") tag = "R3";
      ev = {1'b0, 5'(15 - (int'(ex) - 15) / 2), 10'd0};
    end else begin
      if (tag == "") tag = (ex == 5'd0) ? "R2" : "R1";
      approx = 1;
    end
    if (approx) begin
      x     = fp16_val(op);
      want  = 1.0 / $sqrt(x);
      g     = fp16_val(got);
      bound = (2.0 ** -11.0) + (2.0 ** -14.0);
      report(!got[15] && got[14:10] != 5'd0 && got[14:10] != 5'd31 &&
             ((g > want) ? g - want : want - g) < bound * want,
             tag, $sformatf("lane %0d op %h: got %h expected about %f", i, op, got, want));
    end else begin
      report(got === ev, tag,
             $sformatf("lane %0d op %h: got %h expected %h", i, op, got, ev));
    end
  endtask

  task automatic step(input logic v, input logic [VW-1:0] s, input logic [VW-1:0] d,
                      input logic [L-1:0] m, input logic z, input logic b);
    int sl;
    @(negedge clk_i);
    sl = (cyc + 2) % 4;
    report(valid_o === h_v[sl], "R9",
           $sformatf("valid_o got %b expected %b", valid_o, h_v[sl]));
    if (h_v[sl]) for (int i = 0; i < L; i++) check_lane(i, sl);
    valid_i = v; src_i = s; dst_old_i = d; mask_i = m; zero_mode_i = z; bcast_i = b;
    sl = cyc % 4;
    h_v[sl] = v; h_src[sl] = s; h_dst[sl] = d; h_m[sl] = m; h_z[sl] = z; h_b[sl] = b;
    cyc++;
  endtask

  function automatic logic [15:0] rand_half();
    int c = int'($urandom % 8);
    case (c)
      0, 1, 2, 3: return {1'b0, 5'(1 + $urandom % 30), 10'($urandom)};
      4:          return {1'b0, 5'd0, 10'($urandom)};
      5:          return {1'b1, 15'($urandom)};
      6:          return {1'($urandom), 5'd31, 10'($urandom % 4)};
      default:    return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] s, d;
    void'($urandom(32'd20241));
    for (int k = 0; k < 4; k++) begin
      h_v[k] = 0; h_src[k] = '0; h_dst[k] = '0; h_m[k] = '0; h_z[k] = 0; h_b[k] = 0;
    end
    repeat (3) @(negedge clk_i);
    report(valid_o === 1'b0 && res_o === '0, "R9",
           $sformatf("reset state got %b/%h expected 0/0", valid_o, res_o));
    rst_ni = 1'b1;

    // specials
    step(1, {16'h0001, 16'hC000, 16'h7D23, 16'h7E01, 16'hFC00, 16'h7C00, 16'h8000, 16'h0000},
         '0, 8'hFF, 0, 0);
    // powers of four, back to back
    step(1, {16'h0100, 16'h2C00, 16'h5C00, 16'h0400, 16'h7400, 16'h3400, 16'h4400, 16'h3C00},
         '0, 8'hFF, 0, 0);
    d = {16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666, 16'h7777, 16'h8888};
    // merge and zero masking
    step(1, {8{16'h4200}}, d, 8'hA5, 0, 0);
    step(0, '0, '0, '0, 0, 0);
    step(1, {8{16'h4200}}, d, 8'h5A, 1, 0);
    // broadcast
    step(1, {16'hFFFF, 16'h8000, 16'h7C00, 16'h0000, 16'hC000, 16'h7E00, 16'h1234, 16'h4400},
         d, 8'hFF, 0, 1);
    step(1, {16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00, 16'h7D55},
         d, 8'h0F, 1, 1);
    step(0, '0, '0, '0, 0, 0);
    step(0, '0, '0, '0, 0, 0);

    // sweep of every positive finite encoding
    for (int base = 1; base < 16'h7C00; base += L) begin
      for (int i = 0; i < L; i++)
        s[i*16 +: 16] = (base + i < 16'h7C00) ? 16'(base + i) : 16'h3C00;
      step(1, s, '0, 8'hFF, 0, 0);
    end

    // random mix
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < L; i++) begin
        s[i*16 +: 16] = rand_half();
        d[i*16 +: 16] = 16'($urandom);
      end
      step(($urandom % 8) != 0, s, d, 8'($urandom), 1'($urandom), ($urandom % 4) == 0);
    end

    step(0, '0, '0, '0, 0, 0);
    step(0, '0, '0, '0, 0, 0);
    step(0, '0, '0, '0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule